// File: doc/BRIEF.md
# Decimation Chain Rate Controller

This block generates the sample-valid strobes for a receive decimation chain. The chain has a variable-rate integrator-comb stage followed by two fixed decimate-by-two halfband stages, each of which can be bypassed. The block carries none of the filter arithmetic. It only decides which input samples survive each stage, and it publishes the two halfband enables so that the filters can switch into bypass.

Software sets a single rate word on a write-only settings bus. The word packs the comb factor into its low bits. It also carries two flags, one per halfband, that are filled by removing factors of two from the total rate. If the total is even, the second halfband (bit 8) takes a factor of two. If the remainder is still even, the first halfband (bit 9) takes another. The chain order is comb, then first halfband, then second halfband. The block reports a strobe at the comb output, a strobe at the first halfband output, and the final strobe after the second halfband.

Top module: `decim_rate_ctrl`

## Requirements
- R1: After reset the rate word reads as comb factor 1 with both halfbands disabled, so every valid input sample raises all three strobes. Both enables are 0, and no strobe is high while the input-valid is low.
- R2: A settings write updates the rate word only when its address equals the group base plus 2. Bit 9 of the data is the first-halfband enable and bit 8 is the second-halfband enable. Both enable outputs take the new values in the cycle after the write.
- R3: The comb strobe is high in the same cycle as the N-th valid input sample counted since the last comb strobe or rate write. N is the value of data bits [FACTOR_W-1:0]. Cycles with the input-valid low neither strobe nor advance the count.
- R4: An enabled halfband raises its output strobe on every second incoming strobe, starting with the second one. A disabled halfband copies its incoming strobe in the same cycle.
- R5: In the cycle of a rate write, no strobe is raised even if the input-valid is high. All phase counts restart, so the first final strobe after the write comes one full decimation period later.
- R6: A comb factor of 0 behaves exactly like a factor of 1.
- R7: A write to any other address, or an address match with the write-enable low, leaves the rate word and the strobe pattern unchanged. Data bits between FACTOR_W and 7 are ignored.
- R8: When the rate word comes from factoring a total rate T as described above, the final strobe fires exactly once every T valid input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Settings bus write strobe |
| cfgAddr | input | ADDR_W | Settings bus word address |
| cfgData | input | DATA_W | Settings bus write data |
| inValid | input | 1 | Input sample valid |
| combStb | output | 1 | Comb stage output strobe |
| midStb | output | 1 | First halfband output strobe |
| outStb | output | 1 | Final output strobe (after the second halfband) |
| enFirst | output | 1 | First halfband enable (0 means bypass) |
| enSecond | output | 1 | Second halfband enable (0 means bypass) |

## Verification
The bench builds the block with FACTOR_W set to 4 and the default group base of 160. The narrow factor field makes the largest comb factor, 15, reachable within a short run. It also gives data bit 4 a role as an out-of-field bit that must be ignored. A reference model predicts every cycle's strobes and enables while valid patterns with gaps run against each halfband combination. Zero factors, writes in the middle of a stream, and misaddressed writes are covered. Window counts over factored totals of 12 and 20 then confirm the end-to-end rate.

// File: rtl/drc_pkg.sv
package drc_pkg;

  // Control handed from the register decode to the strobe datapath
  typedef struct packed {
    logic load;      // rate word written this cycle
    logic enFirst;   // first halfband active
    logic enSecond;  // second halfband active
  } drcCtl_t;

  // Strobes along the chain
  typedef struct packed {
    logic comb;
    logic mid;
    logic fin;
  } drcStb_t;

  localparam int FIRST_HB_BIT  = 9;
  localparam int SECOND_HB_BIT = 8;
  localparam int RATE_SLOT     = 2;

endpackage

// File: rtl/drc_ctrl.sv
module drc_ctrl
  import drc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int FACTOR_W  = 8,
  parameter int RATE_ADDR = 162
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [DATA_W-1:0]   cfgData,
  output drcCtl_t             ctl,
  output logic [FACTOR_W-1:0] factor
);

  localparam logic [ADDR_W-1:0] RATE_ADDR_L = ADDR_W'(RATE_ADDR);

  logic [FACTOR_W-1:0] factorQ;
  logic                enFirstQ;
  logic                enSecondQ;
  logic                rateHit;
  logic                unusedData;

  assign unusedData = ^cfgData;
  assign rateHit    = cfgWrEn && (cfgAddr == RATE_ADDR_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      factorQ   <= FACTOR_W'(1);
      enFirstQ  <= 1'b0;
      enSecondQ <= 1'b0;
    end else if (rateHit) begin
      factorQ   <= cfgData[FACTOR_W-1:0];
      enFirstQ  <= cfgData[FIRST_HB_BIT];
      enSecondQ <= cfgData[SECOND_HB_BIT];
    end
  end

  // A zero factor is served as one
  assign factor       = (factorQ == '0) ? FACTOR_W'(1) : factorQ;
  assign ctl.load     = rateHit;
  assign ctl.enFirst  = enFirstQ;
  assign ctl.enSecond = enSecondQ;

  // R2
  rate_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && cfgAddr == RATE_ADDR_L) |=>
      (ctl.enFirst == $past(cfgData[FIRST_HB_BIT]) &&
       ctl.enSecond == $past(cfgData[SECOND_HB_BIT])));

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ctl.enFirst && !ctl.enSecond && factor == FACTOR_W'(1)));

  // R6
  factor_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    factor != '0);

endmodule

// File: rtl/drc_half.sv
module drc_half (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic inStb,
  output logic outStb
);

  logic phase;

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= 1'b0;
    else if (inStb && en) phase <= ~phase;
  end

  assign outStb = en ? (inStb && phase) : inStb;

  // R4
  hb_no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (en && outStb) |=> (!outStb || !en));

  // R4
  hb_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    outStb |-> inStb);

endmodule

// File: rtl/drc_path.sv
module drc_path
  import drc_pkg::*;
#(
  parameter int FACTOR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  drcCtl_t             ctl,
  input  logic [FACTOR_W-1:0] factor,
  input  logic                inValid,
  output drcStb_t             stb
);

  localparam int HB_STAGES = 2;

  logic [FACTOR_W-1:0]  combCnt;
  logic                 combWrap;
  logic [HB_STAGES:0]   chain;
  logic [HB_STAGES-1:0] hbEn;

  assign combWrap = (combCnt == factor - FACTOR_W'(1));

  always_ff @(posedge clk) begin
    if (rst || ctl.load) combCnt <= '0;
    else if (inValid) combCnt <= combWrap ? '0 : combCnt + FACTOR_W'(1);
  end

  assign chain[0] = inValid && !ctl.load && combWrap;
  assign hbEn     = {ctl.enSecond, ctl.enFirst};

  for (genvar g = 0; g < HB_STAGES; g++) begin : gHb
    drc_half uHalf (
      .clk    (clk),
      .rst    (rst),
      .clr    (ctl.load),
      .en     (hbEn[g]),
      .inStb  (chain[g]),
      .outStb (chain[g+1])
    );
  end

  assign stb.comb = chain[0];
  assign stb.mid  = chain[1];
  assign stb.fin  = chain[2];

  // R3 R5
  comb_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stb.comb |-> (inValid && !ctl.load));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    combCnt < factor);

  // R3
  unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (factor == FACTOR_W'(1) && inValid && !ctl.load) |-> stb.comb);

  // R4
  chain_order_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.fin |-> stb.mid) and (stb.mid |-> stb.comb));

endmodule

// File: rtl/decim_rate_ctrl.sv
module decim_rate_ctrl
  import drc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FACTOR_W   = 8,
  parameter int GROUP_BASE = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              inValid,
  output logic              combStb,
  output logic              midStb,
  output logic              outStb,
  output logic              enFirst,
  output logic              enSecond
);

  localparam int RATE_ADDR = GROUP_BASE + RATE_SLOT;

  drcCtl_t             ctl;
  drcStb_t             stb;
  logic [FACTOR_W-1:0] factor;

  drc_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FACTOR_W  (FACTOR_W),
    .RATE_ADDR (RATE_ADDR)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .ctl     (ctl),
    .factor  (factor)
  );

  drc_path #(
    .FACTOR_W (FACTOR_W)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .factor  (factor),
    .inValid (inValid),
    .stb     (stb)
  );

  assign combStb  = stb.comb;
  assign midStb   = stb.mid;
  assign outStb   = stb.fin;
  assign enFirst  = ctl.enFirst;
  assign enSecond = ctl.enSecond;

endmodule

// File: tb/decim_rate_ctrl_bench.sv
module decim_rate_ctrl_bench;

  localparam int FW   = 4;
  localparam int BASE = 160;
  localparam int RA   = BASE + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        cfgWrEn;
  logic [7:0]  cfgAddr;
  logic [31:0] cfgData;
  logic        inValid;
  logic        combStb, midStb, outStb, enFirst, enSecond;

  decim_rate_ctrl #(.FACTOR_W(FW), .GROUP_BASE(BASE)) u_decim_rate_ctrl (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .combStb(combStb), .midStb(midStb), .outStb(outStb),
    .enFirst(enFirst), .enSecond(enSecond)
  );

  int checks = 0;
  int errors = 0;
  int outCount = 0;
  bit done = 0;

  logic [4:0] expQ[$];
  string      tagQ[$];

  // reference state
  int mN = 1;
  bit mFirst = 0, mSecond = 0, mPh1 = 0, mPh2 = 0;
  int mCnt = 0;

  function automatic logic [31:0] packRate(input int total);
    int r = total;
    logic [31:0] w = '0;
    if (r % 2 == 0) begin w[8] = 1'b1; r = r / 2; end
    if (r % 2 == 0) begin w[9] = 1'b1; r = r / 2; end
    w[7:0] = r[7:0];
    return w;
  endfunction

  task automatic step(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                      input bit v, input string tag);
    int effN;
    bit hit, c, a, o;
    @(posedge clk); #1;
    cfgWrEn = wr; cfgAddr = addr; cfgData = data; inValid = v;
    effN = (mN == 0) ? 1 : mN;
    hit  = wr && (addr == 8'(RA));
    c = !hit && v && (mCnt == effN - 1);
    a = mFirst  ? (c && mPh1) : c;
    o = mSecond ? (a && mPh2) : a;
    expQ.push_back({c, a, o, mFirst, mSecond});
    tagQ.push_back(tag);
    if (hit) begin
      mN = int'(data[FW-1:0]); mFirst = data[9]; mSecond = data[8];
      mCnt = 0; mPh1 = 0; mPh2 = 0;
    end else begin
      if (v) mCnt = (mCnt == effN - 1) ? 0 : mCnt + 1;
      if (c && mFirst)  mPh1 = !mPh1;
      if (a && mSecond) mPh2 = !mPh2;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      logic [4:0] e;
      logic [4:0] got;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      got = {combStb, midStb, outStb, enFirst, enSecond};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s comb/mid/out/enF/enS got %b exp %b at %0t", t, got, e, $time);
      end
    end
    if (!rst && outStb) outCount++;
  end

  task automatic windowCheck(input int total, input int expOut, input string tag);
    step(1'b1, 8'(RA), packRate(total), 1'b0, tag);
    outCount = 0;
    for (int i = 0; i < total * expOut; i++) step(1'b0, 8'd0, 32'd0, 1'b1, tag);
    @(negedge clk); #1;
    checks++;
    if (outCount != expOut) begin
      errors++;
      $display("FAIL %s final strobe count got %0d exp %0d", tag, outCount, expOut);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0; inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if ({combStb, midStb, outStb, enFirst, enSecond} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs got %b exp 00000",
               {combStb, midStb, outStb, enFirst, enSecond});
    end
    @(posedge clk); #1; rst = 1'b0;

    // R1: default word passes every valid sample
    for (int i = 0; i < 6; i++) step(1'b0, 8'd0, 32'd0, (i != 3), "R1");

    // R3: comb factor 3 with gapped valids
    step(1'b1, 8'(RA), 32'h003, 1'b0, "R2");
    for (int i = 0; i < 30; i++) step(1'b0, 8'd0, 32'd0, (i % 3) != 1, "R3");

    // R4: first halfband only; write with valid high (R5)
    step(1'b1, 8'(RA), 32'h203, 1'b1, "R5");
    for (int i = 0; i < 40; i++) step(1'b0, 8'd0, 32'd0, (i % 4) != 2, "R4");

    // R4: second halfband only
    step(1'b1, 8'(RA), 32'h102, 1'b0, "R2");
    for (int i = 0; i < 40; i++) step(1'b0, 8'd0, 32'd0, 1'b1, "R4");

    // R4: both halfbands, factor 1
    step(1'b1, 8'(RA), 32'h301, 1'b0, "R4");
    for (int i = 0; i < 40; i++) step(1'b0, 8'd0, 32'd0, (i % 5) != 0, "R4");

    // R6: zero factor
    step(1'b1, 8'(RA), 32'h000, 1'b0, "R6");
    for (int i = 0; i < 8; i++) step(1'b0, 8'd0, 32'd0, (i % 2) == 0, "R6");

    // R7: misaddressed and non-enabled writes are ignored
    step(1'b1, 8'(RA - 1), 32'h305, 1'b1, "R7");
    step(1'b0, 8'(RA), 32'h305, 1'b1, "R7");
    for (int i = 0; i < 10; i++) step(1'b0, 8'd0, 32'd0, 1'b1, "R7");

    // R7: bit above the factor field ignored -> factor 15
    step(1'b1, 8'(RA), 32'h01F, 1'b0, "R7");
    for (int i = 0; i < 35; i++) step(1'b0, 8'd0, 32'd0, 1'b1, "R7");

    // R5: rewrite in mid-stream restarts the phase
    step(1'b1, 8'(RA), 32'h005, 1'b0, "R5");
    for (int i = 0; i < 7; i++) step(1'b0, 8'd0, 32'd0, 1'b1, "R5");
    step(1'b1, 8'(RA), 32'h005, 1'b1, "R5");
    for (int i = 0; i < 6; i++) step(1'b0, 8'd0, 32'd0, 1'b1, "R5");

    // R8: end-to-end rates from factored totals
    windowCheck(12, 10, "R8");
    windowCheck(20, 6, "R8");

    @(negedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule